// File: doc/BRIEF.md
# Power-Good Monitor with Reboot Policy

This block sits in the always-on part of a chip and watches three power status inputs: the main supply power-good, the standby (resume) well reset and the processor regulator power-good. The main power-good and the standby reset are asynchronous. They are brought into the slow real-time clock domain through a synchronizer chain, and every edge decision is made on the synchronized copies. A processor power-good output is formed from the main and regulator power-good inputs. A falling edge of the synchronized main power-good sets a sticky failure flag, which software clears by writing one.

An outage opens when main power-good drops. When it comes back, the block decides whether to ask the platform to reboot. If the standby reset stayed high for the whole outage, the loss counts only as a partial failure and a reboot is always requested. If the standby reset also went low before power-good came back, the event is a full power failure, and the policy bit chooses between rebooting and staying off. In the stay-off state a wake pulse starts the reboot. The block puts no time limit on an outage. Any cap on how long the processor is held in reset must come from outside the block.

Top module: `pgm_power_monitor`

## Requirements
- R1: `main_pg_i` and `rsm_rst_n_i` are sampled only on rising edges of `clk_rtc` through SYNC_STAGES flops (default 2). A low pulse on `main_pg_i` that spans no rising clock edge changes no output.
- R2: With the default PG_OUT_SYNCED=0, `cpu_pg_o` is the combinational AND of `main_pg_i` and `vreg_pg_i`.
- R3: A high-to-low transition of the synchronized main power-good sets `pg_fail_o`. With default parameters the flag is first seen high after the third rising edge that follows the input falling.
- R4: A one-cycle high on `fail_clr_i` clears `pg_fail_o` at the next edge. If a new failure is detected in that same cycle, the flag stays set.
- R5: When main power-good returns and `rsm_rst_n_i` stayed high for the whole outage, `reboot_req_o` pulses for exactly one cycle, whatever the value of `policy_stay_off_i`. With default parameters the pulse is seen after the third rising edge that follows the input rising.
- R6: When `rsm_rst_n_i` went low during the outage (full power failure) and `policy_stay_off_i` is 0 when power returns, the block requests a reboot with the same timing as R5.
- R7: When there is a full power failure and `policy_stay_off_i` is 1 when power returns, there is no reboot pulse and `stay_off_o` goes high. A one-cycle `wake_i` pulse while `stay_off_o` is high clears it and gives one `reboot_req_o` pulse seen after the next rising edge.
- R8: `wake_i` has no effect while the block is not in the stay-off state.
- R9: While main power-good stays low, `reboot_req_o` stays 0 and `cpu_pg_o` stays 0 however long the outage lasts.
- R10: The full-failure record is dropped when the reboot or stay-off decision is made. A later outage in which `rsm_rst_n_i` stays high reboots even with `policy_stay_off_i` = 1.
- R11: While `rst_n` is low and just after it is released, `pg_fail_o`, `reboot_req_o` and `stay_off_o` are 0. Power-good that is already high at release does not request a reboot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rtc | input | 1 | Slow real-time clock; all sampling and state updates |
| rst_n | input | 1 | Asynchronous active-low block reset |
| main_pg_i | input | 1 | Asynchronous main supply power-good |
| rsm_rst_n_i | input | 1 | Asynchronous standby-well reset, active low |
| vreg_pg_i | input | 1 | Processor regulator power-good |
| policy_stay_off_i | input | 1 | 1: stay off after a full power failure; 0: reboot |
| wake_i | input | 1 | Synchronous wake pulse, leaves the stay-off state |
| fail_clr_i | input | 1 | Write-one-to-clear strobe for the failure flag |
| cpu_pg_o | output | 1 | Processor power-good |
| pg_fail_o | output | 1 | Sticky power-good failure flag |
| reboot_req_o | output | 1 | One-cycle reboot request |
| stay_off_o | output | 1 | High while waiting off after a full power failure |

## Verification
The embedded properties assume that `wake_i` and `fail_clr_i` are synchronous to `clk_rtc` and last one cycle. They also assume that the standby reset returns high and settles through the synchronizer before main power-good returns, so the decision never sees both edges at once. The bench changes the asynchronous inputs only on falling clock edges, except for a deliberate sub-period glitch. Every strobe lasts exactly one cycle, and each outage is held for several cycles so that every synchronized edge lands inside its own phase of the outage.

// File: rtl/pgm_pkg.sv
package pgm_pkg;

   typedef enum logic [1:0] {
      PGM_RUN     = 2'd0,
      PGM_OUTAGE  = 2'd1,
      PGM_STAYOFF = 2'd2
   } pgm_state_e;

   localparam int unsigned PGM_MAX_SYNC = 8;

endpackage

// File: rtl/pgm_sync.sv
module pgm_sync #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pgm_sync: STAGES must be at least 2");
   end
   if (STAGES > pgm_pkg::PGM_MAX_SYNC) begin : g_too_deep
      $error("pgm_sync: STAGES exceeds PGM_MAX_SYNC");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("pgm_sync: WIDTH must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/pgm_edge.sv
module pgm_edge #(
   parameter int unsigned WIDTH = 1,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] sig,
   output logic [WIDTH-1:0] rise,
   output logic [WIDTH-1:0] fall
);

   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_VAL;
      else        prev_q <= sig;
   end

   assign rise = sig & ~prev_q;
   assign fall = ~sig & prev_q;

   // R3: a falling edge is flagged only for one cycle per transition
   p_fall_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fall != '0) |=> ((fall & $past(fall)) == '0));

endmodule

// File: rtl/pgm_flag.sv
module pgm_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);

   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag_q <= 1'b0;
      else if (set) flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
   end

   assign flag = flag_q;

   p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> flag);

   p_flag_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> !flag);

   p_flag_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && set) |=> flag);

   p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!set && !clr) |=> $stable(flag));

endmodule

// File: rtl/pgm_policy.sv
module pgm_policy (
   input  logic clk,
   input  logic rst_n,
   input  logic pg_s,
   input  logic pg_rise,
   input  logic pg_fall,
   input  logic rsm_s,
   input  logic policy_stay_off,
   input  logic wake,
   output logic reboot_req,
   output logic stay_off
);

   import pgm_pkg::*;

   pgm_state_e state_q, state_d;
   logic       full_q, full_d;
   logic       reboot_q, reboot_d;
   logic       full_now;

   assign full_now = full_q | ~rsm_s;

   always_comb begin
      state_d  = state_q;
      full_d   = full_q;
      reboot_d = 1'b0;
      unique case (state_q)
         PGM_RUN: begin
            if (pg_fall) begin
               state_d = PGM_OUTAGE;
               full_d  = ~rsm_s;
            end
         end
         PGM_OUTAGE: begin
            if (!rsm_s) full_d = 1'b1;
            if (pg_rise) begin
               full_d = 1'b0;
               if (full_now && policy_stay_off) begin
                  state_d = PGM_STAYOFF;
               end else begin
                  state_d  = PGM_RUN;
                  reboot_d = 1'b1;
               end
            end
         end
         PGM_STAYOFF: begin
            if (pg_fall) begin
               state_d = PGM_OUTAGE;
               full_d  = ~rsm_s;
            end else if (wake && pg_s) begin
               state_d  = PGM_RUN;
               reboot_d = 1'b1;
            end
         end
         default: begin
            state_d = PGM_RUN;
            full_d  = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= PGM_RUN;
         full_q   <= 1'b0;
         reboot_q <= 1'b0;
      end else begin
         state_q  <= state_d;
         full_q   <= full_d;
         reboot_q <= reboot_d;
      end
   end

   assign reboot_req = reboot_q;
   assign stay_off   = (state_q == PGM_STAYOFF);

   p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      reboot_req |=> !reboot_req);

   p_partial_reboots_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PGM_OUTAGE && pg_rise && !full_q && rsm_s) |=> reboot_req);

   p_policy_zero_reboots_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PGM_OUTAGE && pg_rise && !policy_stay_off) |=> reboot_req);

   p_stay_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (stay_off && !wake && !pg_fall) |=> (stay_off && !reboot_req));

   p_wake_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PGM_RUN && wake) |=> !reboot_req);

   p_no_reboot_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!pg_s && !$past(pg_s)) |-> !reboot_req);

   p_full_dropped_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PGM_OUTAGE && pg_rise) |=> !full_q);

   p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(stay_off && reboot_req));

endmodule

// File: rtl/pgm_power_monitor.sv
module pgm_power_monitor #(
   parameter int unsigned SYNC_STAGES   = 2,
   parameter bit          PG_OUT_SYNCED = 1'b0
) (
   input  logic clk_rtc,
   input  logic rst_n,
   input  logic main_pg_i,
   input  logic rsm_rst_n_i,
   input  logic vreg_pg_i,
   input  logic policy_stay_off_i,
   input  logic wake_i,
   input  logic fail_clr_i,
   output logic cpu_pg_o,
   output logic pg_fail_o,
   output logic reboot_req_o,
   output logic stay_off_o
);

   localparam int unsigned IDX_PG  = 0;
   localparam int unsigned IDX_RSM = 1;
   localparam int unsigned NSAMP   = 2;

   logic [NSAMP-1:0] raw_in, samp;
   logic             pg_s, rsm_s, pg_rise, pg_fall;

   assign raw_in[IDX_PG]  = main_pg_i;
   assign raw_in[IDX_RSM] = rsm_rst_n_i;

   pgm_sync #(.WIDTH(NSAMP), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync (
      .clk   (clk_rtc),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (samp)
   );

   assign pg_s  = samp[IDX_PG];
   assign rsm_s = samp[IDX_RSM];

   pgm_edge #(.WIDTH(1), .RST_VAL(1'b0)) u_pg_edge (
      .clk   (clk_rtc),
      .rst_n (rst_n),
      .sig   (pg_s),
      .rise  (pg_rise),
      .fall  (pg_fall)
   );

   pgm_flag u_flag (
      .clk   (clk_rtc),
      .rst_n (rst_n),
      .set   (pg_fall),
      .clr   (fail_clr_i),
      .flag  (pg_fail_o)
   );

   pgm_policy u_policy (
      .clk             (clk_rtc),
      .rst_n           (rst_n),
      .pg_s            (pg_s),
      .pg_rise         (pg_rise),
      .pg_fall         (pg_fall),
      .rsm_s           (rsm_s),
      .policy_stay_off (policy_stay_off_i),
      .wake            (wake_i),
      .reboot_req      (reboot_req_o),
      .stay_off        (stay_off_o)
   );

   if (PG_OUT_SYNCED) begin : g_cpu_pg_sync
      logic vreg_s;
      pgm_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_vreg_sync (
         .clk   (clk_rtc),
         .rst_n (rst_n),
         .d     (vreg_pg_i),
         .q     (vreg_s)
      );
      assign cpu_pg_o = vreg_s & pg_s;
   end else begin : g_cpu_pg_raw
      assign cpu_pg_o = vreg_pg_i & main_pg_i;
      // R2: regulator loss forces processor power-good low
      p_vreg_gates_r2: assert property (@(posedge clk_rtc) disable iff (!rst_n)
         !vreg_pg_i |-> !cpu_pg_o);
   end

   // R9: a request is never issued while the sampled supply is low
   p_req_needs_pg_r9: assert property (@(posedge clk_rtc) disable iff (!rst_n)
      reboot_req_o |-> pg_s);

endmodule

// File: tb/tb_pgm_power_monitor.sv
module tb_pgm_power_monitor;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic main_pg = 1'b1, rsm_n = 1'b1, vreg_pg = 1'b1;
   logic policy = 1'b0, wake = 1'b0, fclr = 1'b0;
   logic cpu_pg, fail_flag, reboot, stay;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   pgm_power_monitor dut (
      .clk_rtc           (clk),
      .rst_n             (rst_n),
      .main_pg_i         (main_pg),
      .rsm_rst_n_i       (rsm_n),
      .vreg_pg_i         (vreg_pg),
      .policy_stay_off_i (policy),
      .wake_i            (wake),
      .fail_clr_i        (fclr),
      .cpu_pg_o          (cpu_pg),
      .pg_fail_o         (fail_flag),
      .reboot_req_o      (reboot),
      .stay_off_o        (stay)
   );

   // fields: {standby reset drops, policy, expect reboot, expect stay-off}
   localparam logic [3:0] VEC [6] = '{
      4'b0010,   // R5 partial loss, policy 0
      4'b0110,   // R5 partial loss, policy 1 still reboots
      4'b1010,   // R6 full failure, policy 0
      4'b1101,   // R7 full failure, policy 1
      4'b0110,   // R10 record dropped: partial loss after stay-off
      4'b1101    // R7 again
   };

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic fclr_pulse();
      fclr = 1'b1;
      cyc(1);
      fclr = 1'b0;
   endtask

   // raise main power-good on a falling edge; count pulses over 8 samples
   task automatic raise_pg(output int pulses, output int first_idx);
      pulses = 0;
      first_idx = -1;
      main_pg = 1'b1;
      for (int k = 1; k <= 8; k++) begin
         cyc(1);
         if (reboot) begin
            pulses++;
            if (first_idx < 0) first_idx = k;
         end
      end
   endtask

   initial begin
      int pulses, idx, viol;
      cyc(1);
      // R11 reset state
      chk("R11 flag in reset", fail_flag, 0);
      chk("R11 reboot in reset", reboot, 0);
      chk("R11 stay in reset", stay, 0);
      cyc(3);
      rst_n = 1'b1;
      pulses = 0;
      for (int k = 0; k < 6; k++) begin
         cyc(1);
         if (reboot) pulses++;
      end
      chk("R11 no reboot after release", pulses, 0);
      chk("R11 flag after release", fail_flag, 0);

      // R2 processor power-good combinations
      for (int c = 0; c < 4; c++) begin
         vreg_pg = c[0];
         main_pg = c[1];
         #2;
         chk("R2 cpu_pg", cpu_pg, c[0] & c[1]);
         cyc(1);
      end
      vreg_pg = 1'b1;
      main_pg = 1'b1;
      cyc(5);
      fclr_pulse();
      cyc(1);
      chk("R4 flag cleared before table", fail_flag, 0);

      // R1 glitch that spans no rising edge
      #2 main_pg = 1'b0;
      #5 main_pg = 1'b1;
      pulses = 0;
      for (int k = 0; k < 6; k++) begin
         cyc(1);
         if (reboot) pulses++;
      end
      chk("R1 glitch flag", fail_flag, 0);
      chk("R1 glitch reboot", pulses, 0);
      chk("R1 glitch stay", stay, 0);

      // R3 flag timing: visible after third edge
      main_pg = 1'b0;
      cyc(2);
      chk("R3 flag not yet", fail_flag, 0);
      cyc(1);
      chk("R3 flag set", fail_flag, 1);
      cyc(4);
      raise_pg(pulses, idx);
      chk("R5 pulses after short loss", pulses, 1);
      chk("R5 pulse cycle", idx, 3);
      chk("R3 flag sticky", fail_flag, 1);

      // R4 set wins over clear (flag already set)
      main_pg = 1'b0;
      cyc(2);
      fclr = 1'b1;
      cyc(1);
      fclr = 1'b0;
      chk("R4 set wins", fail_flag, 1);
      fclr_pulse();
      cyc(1);
      chk("R4 clear", fail_flag, 0);

      // R9 long outage
      viol = 0;
      for (int k = 0; k < 1000; k++) begin
         cyc(1);
         if (reboot || cpu_pg) viol++;
      end
      chk("R9 no reboot or cpu_pg while low", viol, 0);
      raise_pg(pulses, idx);
      chk("R9 reboot after long loss", pulses, 1);
      fclr_pulse();

      // R8 wake in run state
      pulses = 0;
      wake = 1'b1;
      cyc(1);
      wake = 1'b0;
      if (reboot) pulses++;
      cyc(1);
      if (reboot) pulses++;
      chk("R8 wake ignored", pulses, 0);
      chk("R8 stay low", stay, 0);

      // table walk
      foreach (VEC[v]) begin
         policy = VEC[v][2];
         main_pg = 1'b0;
         cyc(6);
         if (VEC[v][3]) begin
            rsm_n = 1'b0;
            cyc(4);
            rsm_n = 1'b1;
            cyc(6);
         end
         chk("R3 flag in outage", fail_flag, 1);
         raise_pg(pulses, idx);
         chk(VEC[v][3] ? (VEC[v][2] ? "R7 pulses" : "R6 pulses")
                       : (v == 4 ? "R10 pulses" : "R5 pulses"),
             pulses, VEC[v][1]);
         if (VEC[v][1]) chk("R5 R6 pulse cycle", idx, 3);
         chk("R7 stay_off", stay, VEC[v][0]);
         if (VEC[v][0]) begin
            wake = 1'b1;
            cyc(1);
            wake = 1'b0;
            chk("R7 wake reboot", reboot, 1);
            chk("R7 wake clears stay", stay, 0);
            cyc(1);
            chk("R7 wake single pulse", reboot, 0);
         end
         fclr_pulse();
         cyc(1);
         chk("R4 flag cleared", fail_flag, 0);
         cyc(2);
      end

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule